// File: doc/BRIEF.md
# End-of-Frame Babble Guard and Keep-Alive Timer

This block runs a frame counter of one millisecond (12000 clocks at 12 MHz) that restarts on every start-of-frame strobe from the host. It uses the tail of each frame for two jobs. If the repeater is still relaying traffic from a downstream port when the next frame start is close, the block asks for that port to be shut off. It also asks for an end-of-packet to be forced toward the host, and it records the fault. Near the end of every frame it also drives a short single-ended-zero pulse onto each enabled low-speed port to keep those devices awake, unless the hub is suspended.

The guard window length is an input, so firmware can tune how early the cut-off happens. Until the first frame start has been seen after reset, the counter free-runs but the guard stays off. That way a hub that has not yet been told the frame timing never cuts a port. The fault flag drives the interrupt output. The index of the first offending port is held until firmware clears the flag.

Top module: `frame_guard_timer`

## Requirements
- R1: The frame counter counts FRAME_CLKS clocks and then wraps. A `sofStrobe` sampled at a clock edge restarts it at zero, so every frame-end action is timed from the most recent frame start.
- R2: Once one frame start has been seen, if `upActive` is high while the counter is within the last `guardLen` counts of the frame, a cut happens. The cut shows as a one-clock pulse on `portDisableReq`, with bit `upSrcIdx` set alone. The pulse appears one clock after the counter first enters the window, that is, FRAME_CLKS-guardLen+1 clocks after the frame-start edge.
- R3: `forceEop` pulses for exactly one clock, in the same cycle as the disable pulse.
- R4: A cut sets `errFlag`, and `irq` is high whenever `errFlag` is high. A one-clock `errClear` drops both; a cut in the same cycle wins. Both are low after reset.
- R5: At most one cut happens per frame, even if `upActive` stays high through the whole window.
- R6: In every frame, `kaSe0` equals `portEnMask & lsMask` for the 16 clocks while the counter runs from FRAME_CLKS-24 to FRAME_CLKS-9. It is zero for the final 8 counts, which leave the line idle (J), and zero at all other times.
- R7: While `suspend` is high, `kaSe0` stays all zero.
- R8: `errPort` takes `upSrcIdx` at a cut only when `errFlag` was clear. Further cuts while the flag is set do not change it.
- R9: No cut happens before the first frame start after reset, whatever `upActive` does.
- R10: If `upActive` falls before the window opens, that frame ends without a cut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-speed bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| sofStrobe | input | 1 | One-clock pulse when a frame-start packet is received |
| upActive | input | 1 | Repeater is relaying a downstream port upstream and waits for its EOP |
| upSrcIdx | input | 2 | Index of the downstream port being relayed |
| portEnMask | input | 4 | Enabled downstream ports |
| lsMask | input | 4 | Downstream ports configured as low speed |
| suspend | input | 1 | Hub is in the suspend state |
| guardLen | input | 8 | Guard window length in clocks before the expected frame start |
| errClear | input | 1 | Firmware clears the fault flag |
| portDisableReq | output | 4 | One-clock one-hot request to disable a port |
| forceEop | output | 1 | One-clock request to send EOP upstream |
| kaSe0 | output | 4 | Per-port drive of the low-speed keep-alive SE0 |
| errFlag | output | 1 | Babble / loss-of-activity fault flag |
| errPort | output | 2 | Port index latched at the first unacknowledged cut |
| irq | output | 1 | Interrupt request |

## Verification
A counter phase that is off by even one clock moves the cut pulse and the keep-alive pulse edges by that clock in the very next frame. So the checks pin each output change to an exact cycle counted from the frame-start edge, rather than merely watching that it happens. A cut-done bit that is not cleared loses the next frame's cut, and one that is never set repeats the pulse. Either shows at the ports within one frame as a missing or surplus scoreboard entry. A corrupted fault latch shows as a wrong `errPort` at the second cut or after the clear.

// File: rtl/ftimer_pkg.sv
package ftimer_pkg;
  // strobes passed from the frame control to the datapath
  typedef struct packed {
    logic cut;    // end-of-frame cut of the active downstream port
    logic kaWin;  // keep-alive SE0 window is open
  } ftStrobe_t;
endpackage

// File: rtl/ftimer_ctrl.sv
module ftimer_ctrl
  import ftimer_pkg::*;
#(
  parameter int FRAME_CLKS = 12000,
  parameter int GUARD_W    = 8,
  parameter int LS_BIT     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sofStrobe,
  input  logic               upActive,
  input  logic [GUARD_W-1:0] guardLen,
  output ftStrobe_t          strobe
);
  localparam int CW = $clog2(FRAME_CLKS);
  localparam logic [CW-1:0] LAST_CNT = CW'(FRAME_CLKS - 1);
  localparam int KA_START = FRAME_CLKS - 3 * LS_BIT;
  localparam int KA_STOP  = FRAME_CLKS - LS_BIT;

  logic [CW-1:0] frameCnt;
  logic synced;
  logic cutDone;
  logic atLast;
  logic inGuard;
  logic cutFire;

  assign atLast  = (frameCnt == LAST_CNT);
  assign inGuard = synced && ((int'(frameCnt) + int'(guardLen)) >= FRAME_CLKS);
  assign cutFire = inGuard && upActive && !cutDone && !sofStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
      synced   <= 1'b0;
      cutDone  <= 1'b0;
    end else begin
      if (sofStrobe || atLast) frameCnt <= '0;
      else                     frameCnt <= frameCnt + 1'b1;
      if (sofStrobe) synced <= 1'b1;
      if (sofStrobe || atLast) cutDone <= 1'b0;
      else if (cutFire)        cutDone <= 1'b1;
    end
  end

  always_comb begin
    strobe.cut   = cutFire;
    strobe.kaWin = (int'(frameCnt) >= KA_START) && (int'(frameCnt) < KA_STOP);
  end

  a_r1_count_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(frameCnt) < FRAME_CLKS);
  a_r1_sof_restart: assert property (@(posedge clk) disable iff (!rstN)
    sofStrobe |=> frameCnt == '0);
  a_r9_no_cut_unsynced: assert property (@(posedge clk) disable iff (!rstN)
    !synced |-> !strobe.cut);
endmodule

// File: rtl/ftimer_dp.sv
module ftimer_dp
  import ftimer_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PW        = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ftStrobe_t            strobe,
  input  logic [PW-1:0]        upSrcIdx,
  input  logic [NUM_PORTS-1:0] portEnMask,
  input  logic [NUM_PORTS-1:0] lsMask,
  input  logic                 suspend,
  input  logic                 errClear,
  output logic [NUM_PORTS-1:0] portDisableReq,
  output logic                 forceEop,
  output logic [NUM_PORTS-1:0] kaSe0,
  output logic                 errFlag,
  output logic [PW-1:0]        errPort,
  output logic                 irq
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      portDisableReq <= '0;
      forceEop       <= 1'b0;
      errFlag        <= 1'b0;
      errPort        <= '0;
    end else begin
      forceEop <= strobe.cut;
      for (int i = 0; i < NUM_PORTS; i++)
        portDisableReq[i] <= strobe.cut && (int'(upSrcIdx) == i);
      if (strobe.cut) begin
        errFlag <= 1'b1;
        if (!errFlag) errPort <= upSrcIdx;
      end else if (errClear) begin
        errFlag <= 1'b0;
      end
    end
  end

  assign kaSe0 = (strobe.kaWin && !suspend) ? (portEnMask & lsMask) : '0;
  assign irq   = errFlag;

  a_r2_onehot_disable: assert property (@(posedge clk) disable iff (!rstN)
    forceEop |-> $countones(portDisableReq) == 1);
  a_r3_eop_single: assert property (@(posedge clk) disable iff (!rstN)
    forceEop |=> !forceEop);
  a_r4_flag_on_cut: assert property (@(posedge clk) disable iff (!rstN)
    forceEop |-> errFlag && irq);
  a_r6_ka_subset: assert property (@(posedge clk) disable iff (!rstN)
    (kaSe0 & ~(portEnMask & lsMask)) == '0);
  a_r7_ka_suspend: assert property (@(posedge clk) disable iff (!rstN)
    suspend |-> kaSe0 == '0);
  a_r8_port_hold: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && $past(errFlag) |-> $stable(errPort));
endmodule

// File: rtl/frame_guard_timer.sv
module frame_guard_timer
  import ftimer_pkg::*;
#(
  parameter int FRAME_CLKS = 12000,
  parameter int NUM_PORTS  = 4,
  parameter int GUARD_W    = 8,
  parameter int LS_BIT     = 8,
  localparam int PW        = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sofStrobe,
  input  logic                 upActive,
  input  logic [PW-1:0]        upSrcIdx,
  input  logic [NUM_PORTS-1:0] portEnMask,
  input  logic [NUM_PORTS-1:0] lsMask,
  input  logic                 suspend,
  input  logic [GUARD_W-1:0]   guardLen,
  input  logic                 errClear,
  output logic [NUM_PORTS-1:0] portDisableReq,
  output logic                 forceEop,
  output logic [NUM_PORTS-1:0] kaSe0,
  output logic                 errFlag,
  output logic [PW-1:0]        errPort,
  output logic                 irq
);
  ftStrobe_t strobe;

  ftimer_ctrl #(.FRAME_CLKS(FRAME_CLKS), .GUARD_W(GUARD_W), .LS_BIT(LS_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .sofStrobe(sofStrobe), .upActive(upActive),
    .guardLen(guardLen), .strobe(strobe)
  );

  ftimer_dp #(.NUM_PORTS(NUM_PORTS), .PW(PW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .upSrcIdx(upSrcIdx),
    .portEnMask(portEnMask), .lsMask(lsMask), .suspend(suspend), .errClear(errClear),
    .portDisableReq(portDisableReq), .forceEop(forceEop), .kaSe0(kaSe0),
    .errFlag(errFlag), .errPort(errPort), .irq(irq)
  );
endmodule

// File: tb/frame_guard_timer_tb_top.sv
`timescale 1ns/1ps
module frame_guard_timer_tb_top;
  localparam int F = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sofStrobe = 1'b0, upActive = 1'b0, suspend = 1'b0, errClear = 1'b0;
  logic [1:0] upSrcIdx = '0;
  logic [3:0] portEnMask = '0, lsMask = '0;
  logic [7:0] guardLen = 8'd32;
  logic [3:0] portDisableReq, kaSe0;
  logic forceEop, errFlag, irq;
  logic [1:0] errPort;

  int cyc = 0;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  typedef struct { int at; logic [3:0] dis; logic [1:0] port; } cutExp_t;
  cutExp_t expQ[$];

  frame_guard_timer #(.FRAME_CLKS(F)) dut_i (
    .clk(clk), .rstN(rstN), .sofStrobe(sofStrobe), .upActive(upActive),
    .upSrcIdx(upSrcIdx), .portEnMask(portEnMask), .lsMask(lsMask), .suspend(suspend),
    .guardLen(guardLen), .errClear(errClear), .portDisableReq(portDisableReq),
    .forceEop(forceEop), .kaSe0(kaSe0), .errFlag(errFlag), .errPort(errPort), .irq(irq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int expv);
    nChecks++;
    if (act != expv) begin
      nFails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, expv);
    end
  endtask

  task automatic pushCut(input int at, input logic [3:0] dis, input logic [1:0] port);
    cutExp_t e;
    e.at = at; e.dis = dis; e.port = port;
    expQ.push_back(e);
  endtask

  task automatic waitTo(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic sendSof(input int target, output int p);
    waitTo(target);
    sofStrobe = 1'b1;
    @(negedge clk);
    sofStrobe = 1'b0;
    p = cyc;
  endtask

  // monitor: every cut pulse is popped from the scoreboard and compared
  always @(negedge clk) begin
    if (rstN && (forceEop || portDisableReq != 4'b0)) begin
      if (expQ.size() == 0) begin
        check("R5/R9/R10 unexpected cut", 1, 0);
      end else begin
        cutExp_t e;
        e = expQ.pop_front();
        check("R2 cut cycle", cyc, e.at);
        check("R2 disable mask", int'(portDisableReq), int'(e.dis));
        check("R3 forceEop", int'(forceEop), 1);
        check("R8 errPort", int'(errPort), int'(e.port));
      end
    end
  end

  task automatic kaScan(input int p, input logic [3:0] mask, input string req);
    for (int k = F - 26; k < F; k++) begin
      waitTo(p + k);
      check(req, int'(kaSe0), (k >= F - 24 && k < F - 8) ? int'(mask) : 0);
    end
  endtask

  initial begin
    int p, p2;
    repeat (4) @(negedge clk);
    check("R4 reset errFlag", int'(errFlag), 0);
    check("R4 reset irq", int'(irq), 0);
    check("R3 reset forceEop", int'(forceEop), 0);
    check("R2 reset disable", int'(portDisableReq), 0);
    rstN = 1'b1;

    // R9: no cut before any frame start
    upActive = 1'b1; upSrcIdx = 2'd1;
    waitTo(cyc + 2 * F + 10);
    check("R9 no flag before sync", int'(errFlag), 0);
    upActive = 1'b0;

    // R2/R3/R4/R5: cut in a synced frame, upActive kept high all frame
    sendSof(cyc + 5, p);
    upActive = 1'b1; upSrcIdx = 2'd2;
    pushCut(p + F - 32 + 1, 4'b0100, 2'd2);
    waitTo(p + F - 2);
    check("R4 flag set", int'(errFlag), 1);
    check("R4 irq high", int'(irq), 1);

    // R8: second cut while flag set keeps first port
    sendSof(p + F - 1, p);
    upSrcIdx = 2'd1;
    pushCut(p + F - 32 + 1, 4'b0010, 2'd2);
    waitTo(p + F - 6);
    check("R8 errPort held", int'(errPort), 2);
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    check("R4 flag cleared", int'(errFlag), 0);
    check("R4 irq cleared", int'(irq), 0);
    upActive = 1'b0;

    // R10: activity ends before the window
    sendSof(p + F - 1, p);
    upActive = 1'b1; upSrcIdx = 2'd3;
    waitTo(p + F - 40);
    upActive = 1'b0;
    waitTo(p + F - 2);
    check("R10 no flag", int'(errFlag), 0);

    // R1: mid-frame resync moves the window; R2 with a shorter guard
    sendSof(p + F - 1, p);
    sendSof(p + 100, p2);
    guardLen = 8'd10; upActive = 1'b1; upSrcIdx = 2'd3;
    pushCut(p2 + F - 10 + 1, 4'b1000, 2'd3);
    waitTo(p2 + F - 3);
    check("R1/R8 errPort after resync", int'(errPort), 3);
    upActive = 1'b0;

    // R6: keep-alive pulse placement and masking
    portEnMask = 4'b1101; lsMask = 4'b0111;
    sendSof(p2 + F - 1, p);
    kaScan(p, 4'b0101, "R6 keep-alive");

    // R7: suspend suppresses keep-alive
    suspend = 1'b1;
    sendSof(p + F - 1, p);
    kaScan(p, 4'b0000, "R7 suspended keep-alive");
    suspend = 1'b0;

    waitTo(cyc + 4);
    check("R2 all expected cuts seen", expQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule